// File: doc/BRIEF.md
# Display Backlight Pulse-Width Modulator

This block drives one pulse-width-modulated line that sets the brightness of a display backlight. Software reaches it through a small word-addressed register port. It writes an on/off bit, a clock prescaler, a period count and a high-time count. The duty ratio high_time / (period + 1) sets the brightness: a ratio near one gives a bright screen and a ratio near zero gives a dark one.

The prescaler, period and high-time fields are double-buffered. Writes land in shadow copies, which software can read back. The counters keep using their active copies until software raises the commit bit from 0 to 1. While the output runs, the new values are then taken over at the end of the current period, so no period is ever cut short or stretched. While the output is off, the new values are taken over on the next clock. Each period starts with the high phase. The high-time field is one bit wider than the period field, so a constant-high output can be programmed.

Top module: `bkl_pwm`

## Requirements
- R1: After reset, every register reads zero, the output is off and `pwm_o` is low.
- R2: Byte offset 0x00 holds the on bit in bit 0. Offset 0x08 holds the commit bit in bit 0. Offset 0x10 holds the 10-bit prescaler in bits 25:16. Offset 0x14 holds the 12-bit period in bits 11:0 and the 13-bit high time in bits 28:16. A read returns the shadow fields, and all other bits and offsets read zero. Read data appears one clock after `rd_addr` is presented.
- R3: Writing the prescaler, period or high-time fields does not change the waveform until a commit.
- R4: While the output is on, a commit (a write that sets commit bit 0 while it holds 0) applies the shadow values at the first period end that falls on a clock edge after the commit write's edge. A commit written on the very edge that ends a period waits for the next period end.
- R5: While the output is off, a commit applies the shadow values on the following clock edge.
- R6: One period lasts (prescaler+1)*(period+1) clocks, and `pwm_o` is high for the first (prescaler+1)*high_time clocks of it. `pwm_o` is registered: after the edge that sets the on bit, it first shows the start of a period one clock later.
- R7: A high time of 0 gives a constant low output, and a high time greater than the period gives a constant high output.
- R8: While the output is off, `pwm_o` is low one clock after the on bit clears. When the output is turned on again, counting restarts at the start of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Registered read data |
| pwm_o | output | 1 | Backlight PWM output |

## Verification
A commit and the end of a period can land on the same clock edge. In that case the pending update must not be applied at that edge, but at the following period end. The bench sets this up by starting the output from a known phase and placing the commit write on exactly the edge that closes the fourth cycle of a four-cycle period. It then predicts, cycle by cycle, where the old values must give way to the new ones and compares every output cycle across the switch. Other cases place the commit inside a period and in the cycle just before a period ends.

// File: rtl/bkl_pkg.sv
package bkl_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int DIV_W   = 10;
  localparam int PER_W   = 12;
  localparam int HW_W    = PER_W + 1;
  localparam int DIV_LSB = 16;
  localparam int HW_LSB  = 16;

  localparam logic [ADDR_W-1:0] OFS_ON  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CMT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CT0 = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CT1 = 5'h14;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [HW_W-1:0]  hw;
  } cfg_t;
endpackage

// File: rtl/bkl_regs.sv
module bkl_regs
  import bkl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              on_q,
  output cfg_t              shadow,
  output logic              commit_rise
);
  logic              cmt_q;
  logic [DATA_W-1:0] rd_mux;

  assign commit_rise = wr_en && (wr_addr == OFS_CMT) && wr_data[0] && !cmt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      cmt_q  <= 1'b0;
      shadow <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_ON:  on_q       <= wr_data[0];
        OFS_CMT: cmt_q      <= wr_data[0];
        OFS_CT0: shadow.div <= wr_data[DIV_LSB +: DIV_W];
        OFS_CT1: begin
          shadow.per <= wr_data[PER_W-1:0];
          shadow.hw  <= wr_data[HW_LSB +: HW_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      OFS_ON:  rd_mux[0] = on_q;
      OFS_CMT: rd_mux[0] = cmt_q;
      OFS_CT0: rd_mux[DIV_LSB +: DIV_W] = shadow.div;
      OFS_CT1: begin
        rd_mux[PER_W-1:0]       = shadow.per;
        rd_mux[HW_LSB +: HW_W]  = shadow.hw;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/bkl_prescale.sv
module bkl_prescale
  import bkl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bkl_wave.sv
module bkl_wave
  import bkl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  cfg_t shadow,
  input  logic commit_rise,
  output cfg_t act,
  output logic pend,
  output logic wrap,
  output logic pwm_o
);
  logic [PER_W-1:0] per_cnt;
  logic             load;

  assign wrap = tick && (per_cnt == act.per);
  assign load = pend && (!run || wrap);

  always_ff @(posedge clk) begin
    if (rst || !run)  per_cnt <= '0;
    else if (wrap)    per_cnt <= '0;
    else if (tick)    per_cnt <= per_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= '0;
      pend <= 1'b0;
    end else begin
      if (load) act <= shadow;
      pend <= (pend && !load) || commit_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= run && ({1'b0, per_cnt} < act.hw);
  end
endmodule

// File: rtl/bkl_pwm.sv
module bkl_pwm
  import bkl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_o
);
  logic on_q;
  logic commit_rise;
  logic tick;
  logic pend;
  logic wrap;
  cfg_t sh;
  cfg_t act;

  bkl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .on_q(on_q), .shadow(sh),
    .commit_rise(commit_rise)
  );

  bkl_prescale u_pre (
    .clk(clk), .rst(rst), .run(on_q), .limit(act.div), .tick(tick)
  );

  bkl_wave u_wave (
    .clk(clk), .rst(rst), .run(on_q), .tick(tick), .shadow(sh),
    .commit_rise(commit_rise), .act(act), .pend(pend), .wrap(wrap), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/bkl_pwm_chk.sv
module bkl_pwm_chk
  import bkl_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic on_q,
  input logic pend,
  input logic wrap,
  input logic commit_rise,
  input cfg_t sh,
  input cfg_t act,
  input logic pwm_o
);
  AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(on_q) |-> !pwm_o); // R8

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    ($past(on_q) && !$past(wrap)) |-> $stable(act)); // R4

  AST_NO_LOAD_UNCOMMITTED: assert property (@(posedge clk) disable iff (rst)
    !$past(pend) |-> $stable(act)); // R3

  AST_LOAD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    ($past(pend) && !$past(on_q)) |-> (act == $past(sh))); // R5

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    commit_rise |=> pend); // R4

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(act.hw) == '0) |-> !pwm_o); // R7

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(on_q) && ($past(act.hw) > {1'b0, $past(act.per)})) |-> pwm_o); // R7
endmodule

bind bkl_pwm bkl_pwm_chk u_chk (
  .clk(clk), .rst(rst), .on_q(on_q), .pend(pend), .wrap(wrap),
  .commit_rise(commit_rise), .sh(sh), .act(act), .pwm_o(pwm_o)
);

// File: tb/sim_bkl_pwm.sv
`timescale 1ns/1ps
module sim_bkl_pwm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pwm_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic  v;
    int    k;
    string tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  bkl_pwm u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops expected output bits one per cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(pwm_o === it.v, it.tag, {31'd0, pwm_o}, {31'd0, it.v});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic setup_off(input int d, input int p, input int h);
    wr_reg(5'h10, d << 16);
    wr_reg(5'h14, (h << 16) | p);
    wr_reg(5'h08, 32'd1);
    wr_reg(5'h08, 32'd0);
  endtask

  function automatic logic wave_bit(input int idx, input int d, input int p, input int h);
    int pc;
    pc = (idx / (d + 1)) % (p + 1);
    return logic'(pc < h);
  endfunction

  // Output already disabled and loaded with A; enable, then switch to B
  task automatic run_case(input int da, input int pa, input int ha,
                          input int db, input int pb, input int hb, input int gap);
    int la, lb, c, j0, m;
    la = (da + 1) * (pa + 1);
    lb = (db + 1) * (pb + 1);
    c  = 3 + gap;
    j0 = la * ((c / la) + 1);
    m  = j0 + 2 * lb + 2;
    wr_reg(5'h00, 32'd1);
    for (int k = 0; k < m; k++) begin
      item_t it;
      it.k = k;
      if (k == 0) begin
        it.v = 1'b0; it.tag = "R6";
      end else if (k - 1 < j0) begin
        it.v = wave_bit(k - 1, da, pa, ha); it.tag = "R3,R5,R6";
      end else begin
        it.v = wave_bit(k - 1 - j0, db, pb, hb); it.tag = "R4,R6,R7";
      end
      sbq.push_back(it);
    end
    wr_reg(5'h10, db << 16);
    wr_reg(5'h14, (hb << 16) | pb);
    for (int g = 0; g < gap; g++) @(negedge clk);
    wr_reg(5'h08, 32'd1);
    wr_reg(5'h08, 32'd0);
    while (sbq.size() != 0) @(negedge clk);
    wr_reg(5'h00, 32'd0);
    @(negedge clk);
    chk(pwm_o === 1'b0, "R8", {31'd0, pwm_o}, 32'd0);
    @(negedge clk);
    chk(pwm_o === 1'b0, "R8", {31'd0, pwm_o}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(pwm_o === 1'b0, "R1", {31'd0, pwm_o}, 32'd0);
    rd_chk(5'h00, 32'd0, "R1");
    rd_chk(5'h08, 32'd0, "R1");
    rd_chk(5'h10, 32'd0, "R1");
    rd_chk(5'h14, 32'd0, "R1");
    // R2: field masks and readback
    wr_reg(5'h10, 32'hFFFF_FFFF);
    wr_reg(5'h14, 32'hFFFF_FFFF);
    rd_chk(5'h10, 32'h03FF_0000, "R2");
    rd_chk(5'h14, 32'h1FFF_0FFF, "R2");
    rd_chk(5'h04, 32'd0, "R2");
    wr_reg(5'h00, 32'hFFFF_FFFE);
    rd_chk(5'h00, 32'd0, "R2");
    wr_reg(5'h08, 32'hFFFF_FFFF);
    rd_chk(5'h08, 32'd1, "R2");
    wr_reg(5'h08, 32'd0);
    rd_chk(5'h08, 32'd0, "R2");
    // R7: constant high with full-scale loaded values while on
    wr_reg(5'h00, 32'd1);
    rd_chk(5'h00, 32'd1, "R2");
    repeat (3) begin
      @(negedge clk);
      chk(pwm_o === 1'b1, "R7", {31'd0, pwm_o}, 32'd1);
    end
    wr_reg(5'h00, 32'd0);
    @(negedge clk);
    chk(pwm_o === 1'b0, "R8", {31'd0, pwm_o}, 32'd0);
    // commit inside a period; new values give a constant high
    setup_off(1, 4, 2);
    run_case(1, 4, 2, 0, 2, 3, 0);
    // commit on the very edge that ends a period; constant low after
    setup_off(0, 3, 1);
    run_case(0, 3, 1, 2, 1, 0, 1);
    // single-clock period, then a divided waveform
    setup_off(0, 0, 1);
    run_case(0, 0, 1, 1, 2, 2, 0);
    finished = 1;
    report();
  end
endmodule